// File: doc/BRIEF.md
# E1 Submultiframe CRC Status Generator

This block watches the receive side of an E1 link running CRC-4 multiframing. For each of the two submultiframes it produces one status flag. A flag reads 1 when the last multiframe was received in multiframe sync and that submultiframe had no CRC error. It reads 0 when the submultiframe carried a CRC error or when alignment was lost. Error pulses and sync drops are gathered in shadow state while a multiframe is in progress. The visible flags are refreshed only when the next receive multiframe-start strobe arrives.

The same flags can be looped back to the far end. When auto-insertion is on and no timeslot-0 transparent mode is active, flag 1 replaces the Si bit of transmit frame 13 and flag 2 replaces the Si bit of transmit frame 15. The transmit frame counter runs 0 to 15 within the multiframe, and the Si bit is bit 1 of timeslot 0. All other transmit frames pass their Si bit through unchanged. In doubleframe format the flags carry no meaning and both read 1.

Top module: `e1_smf_status`

## Requirements
- R1: When `crc_fmt` is 0 (doubleframe), `status_flag` reads 2'b11 in the same cycle, whatever the stored state is.
- R2: With `crc_fmt` at 1, `status_flag` changes only on the clock edge that samples `rx_mf_start` high, and it holds its value on every other edge.
- R3: If `rx_mf_sync` was 0 on any edge from the previous strobe edge up to and including the current strobe edge, both flags read 0 after the current strobe edge.
- R4: A pulse on `rx_smf_err[i]` (bit 0 is submultiframe 1, bit 1 is submultiframe 2) on an edge after the previous strobe edge and before the current one makes `status_flag[i]` read 0 after the current strobe edge. A pulse on the strobe edge itself counts toward the multiframe that is starting.
- R5: A flag reads 1 after a strobe edge only if sync held through the ended multiframe and its submultiframe had no error.
- R6: After reset both stored flags are 0, so `status_flag` reads 2'b00 in CRC format. The first strobe after reset also yields 2'b00, because no complete multiframe has been observed yet.
- R7: With `tx_auto_en`=1 and `ts0_transp`=0, `tx_si_out` equals `status_flag[0]` when `tx_frame_idx`=13 and equals `status_flag[1]` when `tx_frame_idx`=15. This is combinational, in the same cycle.
- R8: With `tx_auto_en`=0 or `ts0_transp`=1, `tx_si_out` equals `tx_si_in` in every frame.
- R9: For `tx_frame_idx` values other than 13 and 15, `tx_si_out` equals `tx_si_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_mf_start | input | 1 | One-cycle strobe at the start of each received CRC multiframe |
| rx_smf_err | input | 2 | Per-submultiframe CRC error pulses; bit 0 is submultiframe 1 |
| rx_mf_sync | input | 1 | High while the receiver is in multiframe sync |
| crc_fmt | input | 1 | 1 selects CRC multiframe format, 0 selects doubleframe |
| tx_auto_en | input | 1 | Enables looping the flags into the transmit Si bits |
| ts0_transp | input | 1 | High while any timeslot-0 transparent mode is active |
| tx_frame_idx | input | 4 | Transmit frame number within the multiframe, 0 to 15 |
| tx_si_in | input | 1 | Transmit Si bit before substitution |
| status_flag | output | 2 | Submultiframe status flags; bit 0 is flag 1 |
| tx_si_out | output | 1 | Transmit Si bit after substitution |

## Verification
The assertions take the strobe as a plain edge marker and place no limit on its spacing. They do assume that `tx_frame_idx` changes only between edges, because the Si checks are sampled at the clock. The stimulus drives every input half a cycle away from the active edge. It places strobes every 16 cycles in the normal runs and draws error pulses, sync drops, format, transparency and frame numbers at random. Directed cases put an error pulse exactly on a strobe edge and drop sync for a single cycle, since these are the edges of the accumulation window.

// File: rtl/smfs_pkg.sv
package smfs_pkg;
  localparam int SMF_N     = 2;
  localparam int MF_FRAMES = 16;
  localparam int FIDX_W    = $clog2(MF_FRAMES);

  // Transmit frame carrying the Si bit for submultiframe i: 13, 15
  function automatic logic [FIDX_W-1:0] si_frame(input int i);
    return FIDX_W'(MF_FRAMES - 3 + 2 * i);
  endfunction

  // Flag value latched at a multiframe boundary
  function automatic logic smf_flag(input logic sync_now, input logic lost_acc,
                                    input logic err_acc);
    return sync_now & ~lost_acc & ~err_acc;
  endfunction
endpackage

// File: rtl/smfs_shadow.sv
module smfs_shadow #(
  parameter int N = smfs_pkg::SMF_N
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mf_start,
  input  logic         sync_ok,
  input  logic [N-1:0] err_in,
  output logic [N-1:0] err_acc,
  output logic         lost_acc
);
  // Errors on the strobe edge belong to the new multiframe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_acc  <= '0;
      lost_acc <= 1'b1;
    end else if (mf_start) begin
      err_acc  <= err_in;
      lost_acc <= ~sync_ok;
    end else begin
      err_acc  <= err_acc | err_in;
      lost_acc <= lost_acc | ~sync_ok;
    end
  end

  p_lost_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mf_start && !sync_ok) |=> lost_acc);
  p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mf_start && (err_in != '0)) |=> ((err_acc & $past(err_in)) == $past(err_in)));
endmodule

// File: rtl/smfs_flags.sv
module smfs_flags #(
  parameter int N = smfs_pkg::SMF_N
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mf_start,
  input  logic         sync_ok,
  input  logic         crc_fmt,
  input  logic [N-1:0] err_acc,
  input  logic         lost_acc,
  output logic [N-1:0] flag_q,
  output logic [N-1:0] flag_vis
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag_q[i] <= 1'b0;
      else if (mf_start) flag_q[i] <= smfs_pkg::smf_flag(sync_ok, lost_acc, err_acc[i]);
    end

    p_err_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mf_start && err_acc[i]) |=> !flag_q[i]);
  end

  assign flag_vis = crc_fmt ? flag_q : '1;

  p_dblfrm_ones_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !crc_fmt |-> (flag_vis == '1));
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mf_start |=> $stable(flag_q));
  p_lost_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mf_start && (lost_acc || !sync_ok)) |=> (flag_q == '0));
  p_clean_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mf_start && sync_ok && !lost_acc && (err_acc == '0)) |=> (flag_q == '1));
endmodule

// File: rtl/smfs_si_ins.sv
module smfs_si_ins #(
  parameter int N  = smfs_pkg::SMF_N,
  parameter int FW = smfs_pkg::FIDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  flag_vis,
  input  logic          auto_en,
  input  logic          transp,
  input  logic [FW-1:0] frame_idx,
  input  logic          si_in,
  output logic          si_out
);
  logic          ins_ok;
  logic [N-1:0]  hit;

  assign ins_ok = auto_en & ~transp;

  for (genvar i = 0; i < N; i++) begin : g_hit
    assign hit[i] = (frame_idx == smfs_pkg::si_frame(i));
  end

  always_comb begin
    si_out = si_in;
    for (int i = 0; i < N; i++) begin
      if (ins_ok && hit[i]) si_out = flag_vis[i];
    end
  end

  p_ins13_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && !transp && frame_idx == FW'(13)) |-> (si_out == flag_vis[0]));
  p_ins15_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && !transp && frame_idx == FW'(15)) |-> (si_out == flag_vis[N-1]));
  p_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_en || transp) |-> (si_out == si_in));
  p_other_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_idx != FW'(13) && frame_idx != FW'(15)) |-> (si_out == si_in));
endmodule

// File: rtl/e1_smf_status.sv
module e1_smf_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_mf_start,
  input  logic [1:0] rx_smf_err,
  input  logic       rx_mf_sync,
  input  logic       crc_fmt,
  input  logic       tx_auto_en,
  input  logic       ts0_transp,
  input  logic [3:0] tx_frame_idx,
  input  logic       tx_si_in,
  output logic [1:0] status_flag,
  output logic       tx_si_out
);
  localparam int N  = smfs_pkg::SMF_N;
  localparam int FW = smfs_pkg::FIDX_W;

  logic [N-1:0] err_acc;
  logic         lost_acc;
  logic [N-1:0] flag_q;

  smfs_shadow #(.N(N)) u_shadow (
    .clk(clk), .rst_n(rst_n), .mf_start(rx_mf_start), .sync_ok(rx_mf_sync),
    .err_in(rx_smf_err), .err_acc(err_acc), .lost_acc(lost_acc)
  );

  smfs_flags #(.N(N)) u_flags (
    .clk(clk), .rst_n(rst_n), .mf_start(rx_mf_start), .sync_ok(rx_mf_sync),
    .crc_fmt(crc_fmt), .err_acc(err_acc), .lost_acc(lost_acc),
    .flag_q(flag_q), .flag_vis(status_flag)
  );

  smfs_si_ins #(.N(N), .FW(FW)) u_si (
    .clk(clk), .rst_n(rst_n), .flag_vis(status_flag), .auto_en(tx_auto_en),
    .transp(ts0_transp), .frame_idx(tx_frame_idx), .si_in(tx_si_in),
    .si_out(tx_si_out)
  );

  p_reset_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rst_n) && crc_fmt) |-> (status_flag == 2'b00));
endmodule

// File: tb/e1_smf_status_bench.sv
`timescale 1ns/1ps
module e1_smf_status_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_mf_start = 1'b0;
  logic [1:0] rx_smf_err = 2'b00;
  logic       rx_mf_sync = 1'b1;
  logic       crc_fmt = 1'b1;
  logic       tx_auto_en = 1'b0;
  logic       ts0_transp = 1'b0;
  logic [3:0] tx_frame_idx = 4'd0;
  logic       tx_si_in = 1'b0;
  logic [1:0] status_flag;
  logic       tx_si_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // Bench model state
  logic [1:0] m_flag = 2'b00;
  logic [1:0] m_err  = 2'b00;
  logic       m_lost = 1'b1;

  always #4 clk = ~clk;

  e1_smf_status u_e1_smf_status (
    .clk(clk), .rst_n(rst_n), .rx_mf_start(rx_mf_start), .rx_smf_err(rx_smf_err),
    .rx_mf_sync(rx_mf_sync), .crc_fmt(crc_fmt), .tx_auto_en(tx_auto_en),
    .ts0_transp(ts0_transp), .tx_frame_idx(tx_frame_idx), .tx_si_in(tx_si_in),
    .status_flag(status_flag), .tx_si_out(tx_si_out)
  );

  function automatic logic [1:0] vis_flags();
    return crc_fmt ? m_flag : 2'b11;
  endfunction

  function automatic logic exp_si();
    logic [1:0] v = vis_flags();
    if (!tx_auto_en || ts0_transp) return tx_si_in;
    if (tx_frame_idx == 4'd13) return v[0];
    if (tx_frame_idx == 4'd15) return v[1];
    return tx_si_in;
  endfunction

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // One cycle: inputs already set at negedge
  task automatic tick();
    string tag;
    #1;
    if (!tx_auto_en || ts0_transp) tag = "R8";
    else if (tx_frame_idx == 4'd13 || tx_frame_idx == 4'd15) tag = "R7";
    else tag = "R9";
    chk(tag, {1'b0, tx_si_out}, {1'b0, exp_si()});
    @(posedge clk);
    if (rx_mf_start) begin
      m_flag[0] = rx_mf_sync & ~m_lost & ~m_err[0];
      m_flag[1] = rx_mf_sync & ~m_lost & ~m_err[1];
      m_err  = rx_smf_err;
      m_lost = ~rx_mf_sync;
    end else begin
      m_err  = m_err | rx_smf_err;
      m_lost = m_lost | ~rx_mf_sync;
    end
    @(negedge clk);
    chk(crc_fmt ? "R2 R3 R4 R5" : "R1", status_flag, vis_flags());
    rx_mf_start = 1'b0;
    rx_smf_err  = 2'b00;
    rx_mf_sync  = 1'b1;
  endtask

  // One multiframe of 16 cycles; -1 disables the event
  task automatic mf(input int err_cyc, input logic [1:0] err_v, input int drop_cyc);
    for (int c = 0; c < 16; c++) begin
      rx_mf_start  = (c == 0);
      rx_smf_err   = (c == err_cyc) ? err_v : 2'b00;
      rx_mf_sync   = (c != drop_cyc);
      tx_frame_idx = 4'(c);
      tx_si_in     = c[0];
      tick();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int unsigned seed = 32'd1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R6", status_flag, 2'b00);

    tx_auto_en = 1'b1;
    mf(-1, 2'b00, -1);
    chk("R6", status_flag, 2'b00);
    mf(-1, 2'b00, -1);
    mf(-1, 2'b00, -1);
    chk("R5", status_flag, 2'b11);
    mf(5, 2'b01, -1);
    mf(-1, 2'b00, -1);
    chk("R4", status_flag, 2'b10);
    mf(-1, 2'b00, 7);
    mf(-1, 2'b00, -1);
    chk("R3", status_flag, 2'b00);
    mf(-1, 2'b00, -1);
    mf(0, 2'b10, -1);
    chk("R4", status_flag, 2'b11);
    mf(-1, 2'b00, -1);
    chk("R4", status_flag, 2'b01);

    // Si substitution directed, flags now 01
    tx_frame_idx = 4'd13; tx_si_in = 1'b0; #1;
    chk("R7", {1'b0, tx_si_out}, 2'b01);
    tx_frame_idx = 4'd15; tx_si_in = 1'b1; #1;
    chk("R7", {1'b0, tx_si_out}, 2'b00);
    ts0_transp = 1'b1; #1;
    chk("R8", {1'b0, tx_si_out}, 2'b01);
    ts0_transp = 1'b0; tx_frame_idx = 4'd14; tx_si_in = 1'b0; #1;
    chk("R9", {1'b0, tx_si_out}, 2'b00);
    @(negedge clk);

    crc_fmt = 1'b0; #1;
    chk("R1", status_flag, 2'b11);
    mf(3, 2'b11, 4);
    chk("R1", status_flag, 2'b11);
    crc_fmt = 1'b1;

    // Random multiframes
    for (int k = 0; k < 300; k++) begin
      for (int c = 0; c < 16; c++) begin
        rx_mf_start  = (c == 0) ? (($urandom % 8) != 0) : (($urandom % 64) == 0);
        rx_smf_err   = (($urandom % 20) == 0) ? 2'($urandom) : 2'b00;
        rx_mf_sync   = (($urandom % 40) != 0);
        tx_auto_en   = (($urandom % 4) != 0);
        ts0_transp   = (($urandom % 5) == 0);
        tx_frame_idx = (($urandom % 3) == 0) ? 4'(13 + 2 * ($urandom % 2)) : 4'($urandom);
        tx_si_in     = 1'($urandom);
        if (c == 0 && ($urandom % 16) == 0) crc_fmt = ~crc_fmt;
        tick();
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule